// File: doc/BRIEF.md
# Four-Phase Instruction Sequencer

This block is the timing and control core of a small accumulator processor. It divides the incoming clock into four phases, one clock each, that rotate in a fixed order. One full rotation is one instruction cycle. While one instruction executes, the next word is fetched from program memory. Straight-line code therefore retires one instruction per instruction cycle.

The block owns the program counter, the instruction register, a two-entry return stack and the handling of pipeline flushes. Execute logic outside the block decodes the current instruction. It reports a control transfer on a small operation code with a target address. The block drives phase-qualified strobes for the data-memory read and write slots. A taken transfer discards the word already prefetched and puts an all-zero no-op in its place, so every transfer costs two instruction cycles.

Top module: `qps_sequencer`

## Requirements
- R1: `phase` is one-hot at every clock after reset and steps Q1 (bit 0), Q2 (bit 1), Q3 (bit 2), Q4 (bit 3), then back to Q1, advancing one bit per clock; four clocks form one instruction cycle.
- R2: `dmem_rd` is high exactly in the Q2 clock and `dmem_wr` exactly in the Q4 clock of every instruction cycle.
- R3: A clock edge with `rst_n` low puts the block into Q1, sets `pmem_addr` to `RESET_VEC` and loads `cur_instr` with `NOP_WORD` (all zeros by default).
- R4: `pmem_data` is captured at the clock ending Q4 and is shown on `cur_instr` for all four phases of the next instruction cycle. At that same edge `pmem_addr` moves to the next address, modulo 2^AW. Neither `pmem_addr` nor `cur_instr` changes at any other edge.
- R5: With no transfer requested, successive instruction cycles execute successive program words. The instruction cycle that follows reset executes the no-op.
- R6: `br_op` and `br_target` are sampled only at the clock ending Q4. A non-zero `br_op` in Q1, Q2 or Q3 has no effect. Encoding of `br_op`: 0 none, 1 jump, 2 call, 3 return.
- R7: A jump or call taken at the end of a cycle replaces the prefetched word with the no-op for the next cycle and fetches from `br_target` in that cycle, so the target executes two cycles after the transfer.
- R8: A call pushes the address of the word after the call onto the return stack. A return ignores `br_target` and fetches from the most recently pushed address, then drops it.
- R9: The stack holds two entries. A third nested call discards the oldest entry. A return on an empty stack yields the last value still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pmem_addr | output | AW | Program-memory fetch address |
| pmem_data | input | IW | Word read from program memory |
| dmem_rd | output | 1 | Operand read strobe (Q2) |
| dmem_wr | output | 1 | Destination write strobe (Q4) |
| br_op | input | 2 | Transfer request from execute logic |
| br_target | input | AW | Destination of a jump or call |
| cur_instr | output | IW | Instruction being executed |
| phase | output | 4 | One-hot phase, bit 0 = Q1 |

## Verification
The bench builds the sequencer with a 6-bit address and a reset vector of 0x3C. With these values the straight-line run crosses the top of the address space within a few cycles. A 64-word program is small enough to compute as a function of the address. In that program, calls nest three deep. The trace therefore covers the loss of the oldest return address, a return on an empty stack and a repeating jump/return loop. Every phase clock of each traced cycle is checked. A second pass after a fresh reset holds a jump request through Q1 to Q3 only and shows that it is ignored.

// File: rtl/qps_pkg.sv
// Shared definitions for the four-phase sequencer.
// Assumes: phase vectors are one-hot with bit 0 = Q1.
package qps_pkg;

    typedef enum logic [1:0] {
        XFER_NONE   = 2'd0,
        XFER_JUMP   = 2'd1,
        XFER_CALL   = 2'd2,
        XFER_RETURN = 2'd3
    } xfer_e;

    localparam int PH_Q1 = 0;
    localparam int PH_Q2 = 1;
    localparam int PH_Q3 = 2;
    localparam int PH_Q4 = 3;
    localparam int NUM_PHASES = 4;

endpackage

// File: rtl/qps_phase_ring.sv
// Phase generator: a four-bit one-hot ring that advances once per clock.
// Assumes: synchronous active-low reset; reset parks the ring in Q1.
module qps_phase_ring
    import qps_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [NUM_PHASES-1:0] phase_o
);

    localparam logic [NUM_PHASES-1:0] START = NUM_PHASES'(1) << PH_Q1;

    // Rotate the one-hot token towards the next phase every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o <= START;
        end else begin
            phase_o <= {phase_o[NUM_PHASES-2:0], phase_o[NUM_PHASES-1]};
        end
    end

    // R1
    one_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_o) == 1);

    // R1
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o[PH_Q4] |=> phase_o[PH_Q1]);

endmodule

// File: rtl/qps_ret_stack.sv
// Return-address stack of DEPTH entries, with entry 0 on top.
// Assumes: push and pop are never asserted together. A push when full
// drops the bottom entry. A pop leaves the bottom entry in place, so
// an empty stack keeps returning its last value.
module qps_ret_stack #(
    parameter int AW    = 9,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] push_val_i,
    output logic [AW-1:0] top_o
);

    logic [AW-1:0] ent [DEPTH];

    // Shift entries down on push and up on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else if (push_i) begin
            ent[0] <= push_val_i;
            for (int i = 1; i < DEPTH; i++) ent[i] <= ent[i-1];
        end else if (pop_i) begin
            for (int i = 0; i < DEPTH - 1; i++) ent[i] <= ent[i+1];
        end
    end

    assign top_o = ent[0];

    // R8
    push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> top_o == $past(push_val_i));

    generate
        if (DEPTH > 1) begin : g_deep
            // R9
            pop_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pop_i |=> top_o == $past(ent[1]));
            // R9
            bottom_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pop_i |=> ent[DEPTH-1] == $past(ent[DEPTH-1]));
        end
    endgenerate

endmodule

// File: rtl/qps_fetch_unit.sv
// Program counter and instruction register.
// Assumes: step_i is high in the last clock of each instruction cycle.
// At that edge the fetched word moves into the instruction register
// and the counter advances, or both are redirected by a taken transfer.
module qps_fetch_unit #(
    parameter int              AW        = 9,
    parameter int              IW        = 12,
    parameter logic [AW-1:0]   RESET_VEC = '1,
    parameter logic [IW-1:0]   NOP_WORD  = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          taken_i,
    input  logic [AW-1:0] tgt_i,
    input  logic [IW-1:0] fetch_word_i,
    output logic [AW-1:0] pc_o,
    output logic [IW-1:0] ir_o
);

    localparam logic [AW-1:0] ONE = AW'(1);

    // Advance or redirect the fetch address at each cycle boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o <= RESET_VEC;
        end else if (step_i) begin
            pc_o <= taken_i ? tgt_i : pc_o + ONE;
        end
    end

    // Latch the fetched word, or squash it to a no-op after a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_o <= NOP_WORD;
        end else if (step_i) begin
            ir_o <= taken_i ? NOP_WORD : fetch_word_i;
        end
    end

    // R4
    hold_mid_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(pc_o) && $stable(ir_o));

    // R4
    seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !taken_i) |=> pc_o == $past(pc_o) + ONE);

    // R7
    flush_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && taken_i) |=> ir_o == NOP_WORD);

    // R7
    redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && taken_i) |=> pc_o == $past(tgt_i));

endmodule

// File: rtl/qps_sequencer.sv
// Four-phase fetch/execute sequencer: phase ring, fetch unit and return
// stack, plus the data-memory strobes.
// Assumes: execute logic holds br_op and br_target valid in Q4 of the
// cycle that executes a transfer. The request is sampled only there.
module qps_sequencer
    import qps_pkg::*;
#(
    parameter int            AW        = 9,
    parameter int            IW        = 12,
    parameter int            DEPTH     = 2,
    parameter logic [AW-1:0] RESET_VEC = '1,
    parameter logic [IW-1:0] NOP_WORD  = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [AW-1:0]         pmem_addr,
    input  logic [IW-1:0]         pmem_data,
    output logic                  dmem_rd,
    output logic                  dmem_wr,
    input  logic [1:0]            br_op,
    input  logic [AW-1:0]         br_target,
    output logic [IW-1:0]         cur_instr,
    output logic [NUM_PHASES-1:0] phase
);

    xfer_e         op;
    logic          step;
    logic          taken;
    logic          push;
    logic          pop;
    logic [AW-1:0] stack_top;
    logic [AW-1:0] next_tgt;

    qps_phase_ring u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase)
    );

    // Qualify the transfer request with the last phase of the cycle.
    always_comb begin
        op       = xfer_e'(br_op);
        step     = phase[PH_Q4];
        taken    = step && (op != XFER_NONE);
        push     = step && (op == XFER_CALL);
        pop      = step && (op == XFER_RETURN);
        next_tgt = (op == XFER_RETURN) ? stack_top : br_target;
    end

    qps_ret_stack #(
        .AW    (AW),
        .DEPTH (DEPTH)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .pop_i      (pop),
        .push_val_i (pmem_addr),
        .top_o      (stack_top)
    );

    qps_fetch_unit #(
        .AW        (AW),
        .IW        (IW),
        .RESET_VEC (RESET_VEC),
        .NOP_WORD  (NOP_WORD)
    ) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_i       (step),
        .taken_i      (taken),
        .tgt_i        (next_tgt),
        .fetch_word_i (pmem_data),
        .pc_o         (pmem_addr),
        .ir_o         (cur_instr)
    );

    // Operand read slot in Q2, destination write slot in Q4.
    always_comb begin
        dmem_rd = phase[PH_Q2];
        dmem_wr = phase[PH_Q4];
    end

    // R2
    strobe_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_rd |=> (!dmem_rd && !dmem_wr) ##1 dmem_wr);

    // R6
    early_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_op != 2'd0 && !phase[PH_Q4]) |=> $stable(cur_instr) && $stable(pmem_addr));

endmodule

// File: tb/qps_sequencer_test.sv
// Self-checking bench for qps_sequencer: 6-bit addresses, reset vector
// 0x3C. The program is computed from the address. The bench decodes
// cur_instr as the execute logic would: tag in bits 11:6, argument in
// bits 5:0.
module qps_sequencer_test;

    localparam int            AW   = 6;
    localparam int            IW   = 12;
    localparam logic [AW-1:0] RVEC = 6'h3C;

    localparam logic [5:0] T_PLAIN = 6'h01;
    localparam logic [5:0] T_JMP   = 6'h2A;
    localparam logic [5:0] T_CALL  = 6'h2B;
    localparam logic [5:0] T_RET   = 6'h2C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] pmem_addr;
    logic [IW-1:0] pmem_data = '0;
    logic          dmem_rd;
    logic          dmem_wr;
    logic [1:0]    br_op = 2'd0;
    logic [AW-1:0] br_target = '0;
    logic [IW-1:0] cur_instr;
    logic [3:0]    phase;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    qps_sequencer #(
        .AW        (AW),
        .IW        (IW),
        .DEPTH     (2),
        .RESET_VEC (RVEC),
        .NOP_WORD  ('0)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pmem_addr (pmem_addr),
        .pmem_data (pmem_data),
        .dmem_rd   (dmem_rd),
        .dmem_wr   (dmem_wr),
        .br_op     (br_op),
        .br_target (br_target),
        .cur_instr (cur_instr),
        .phase     (phase)
    );

    always #10 clk = ~clk;

    // Program image as a function of the address.
    function automatic logic [IW-1:0] prog(input logic [AW-1:0] a);
        case (a)
            6'h01:   return {T_CALL, 6'h10};
            6'h10:   return {T_CALL, 6'h18};
            6'h18:   return {T_CALL, 6'h30};
            6'h30:   return {T_RET, 6'h00};
            6'h19:   return {T_RET, 6'h00};
            6'h11:   return {T_JMP, 6'h20};
            6'h20:   return {T_RET, 6'h00};
            default: return {T_PLAIN, a};
        endcase
    endfunction

    // Address executed in instruction cycle c of the main trace; -1 = no-op.
    function automatic int exec_addr(input int c);
        case (c)
            1: return 'h3C;  2: return 'h3D;  3: return 'h3E;  4: return 'h3F;
            5: return 'h00;  6: return 'h01;  8: return 'h10;  10: return 'h18;
            12: return 'h30; 14: return 'h19; 16: return 'h11; 18: return 'h20;
            20: return 'h11; 22: return 'h20;
            default: return -1;
        endcase
    endfunction

    // Address being fetched in instruction cycle c of the main trace.
    function automatic int fetch_addr(input int c);
        case (c)
            0: return 'h3C;  1: return 'h3D;  2: return 'h3E;  3: return 'h3F;
            4: return 'h00;  5: return 'h01;  6: return 'h02;  7: return 'h10;
            8: return 'h11;  9: return 'h18;  10: return 'h19; 11: return 'h30;
            12: return 'h31; 13: return 'h19; 14: return 'h1A; 15: return 'h11;
            16: return 'h12; 17: return 'h20; 18: return 'h21; 19: return 'h11;
            20: return 'h12; 21: return 'h20; 22: return 'h21; 23: return 'h11;
            default: return 0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic check_reset_state();
        // R3
        check(phase == 4'b0001, "R3 phase", int'(phase), 1);
        check(pmem_addr == RVEC, "R3 pmem_addr", int'(pmem_addr), int'(RVEC));
        check(cur_instr == '0, "R3 cur_instr", int'(cur_instr), 0);
    endtask

    // Runs ncyc instruction cycles from a negedge right after reset.
    // inject=0: br_op comes from decoding cur_instr, driven in Q4 only.
    // inject=1: a jump to 0x2A is held in Q1..Q3 and dropped in Q4.
    task automatic run(input int ncyc, input bit inject);
        for (int k = 0; k < ncyc * 4; k++) begin
            int c  = k / 4;
            int ph = k % 4;
            // R1
            check(phase == 4'(1 << ph), "R1 phase order", int'(phase), 1 << ph);
            check($countones(phase) == 1, "R1 one-hot", int'(phase), 1 << ph);
            // R2
            check(dmem_rd == (ph == 1), "R2 dmem_rd", int'(dmem_rd), int'(ph == 1));
            check(dmem_wr == (ph == 3), "R2 dmem_wr", int'(dmem_wr), int'(ph == 3));
            if (ph == 1 && !inject) begin
                int ea = exec_addr(c);
                logic [IW-1:0] ei = (ea < 0) ? '0 : prog(AW'(ea));
                // R5 R7 R8 R9
                check(cur_instr == ei, "R5/R7/R8/R9 cur_instr", int'(cur_instr), int'(ei));
                check(int'(pmem_addr) == fetch_addr(c), "R4/R7/R8/R9 pmem_addr",
                      int'(pmem_addr), fetch_addr(c));
            end
            if (ph == 1 && inject) begin
                logic [AW-1:0] fa = RVEC + AW'(c);
                logic [IW-1:0] ei = (c == 0) ? '0 : prog(RVEC + AW'(c - 1));
                // R6
                check(pmem_addr == fa, "R6 pmem_addr", int'(pmem_addr), int'(fa));
                check(cur_instr == ei, "R6 cur_instr", int'(cur_instr), int'(ei));
            end
            // R4: data presented from the current fetch address.
            pmem_data = prog(pmem_addr);
            if (inject) begin
                br_op     = (ph != 3) ? 2'd1 : 2'd0;
                br_target = 6'h2A;
            end else if (ph == 3) begin
                case (cur_instr[11:6])
                    T_JMP:   br_op = 2'd1;
                    T_CALL:  br_op = 2'd2;
                    T_RET:   br_op = 2'd3;
                    default: br_op = 2'd0;
                endcase
                br_target = cur_instr[5:0];
            end else begin
                br_op = 2'd0;
            end
            @(negedge clk);
        end
        br_op = 2'd0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_reset_state();
        run(24, 1'b0);
        // Fresh reset, then requests outside Q4 only.
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_reset_state();
        run(6, 1'b1);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule